// File: doc/BRIEF.md
# Legacy INTx Interrupt Status and Mask Register

This block gathers the four level-sensitive legacy PCI interrupt lines, INTA through INTD, into one 32-bit control register. Each line latches a pending status bit that stays set until software clears it. A per-line enable decides whether that pending bit reaches the single combined interrupt output. The combined output goes to a host interrupt controller.

The same register also holds some fields that the block only stores and reads back. These are the enables for bus error events, the master request priority bits and a TRDY wait count. Software reaches the register through a simple write port with byte enables and a combinational read port.

The status bits are write-one-to-clear. A read-modify-write that writes zeros into the status field therefore leaves pending interrupts in place. A halfword write of 0xF000 to the upper half clears all pending status and every enable held in that half.

Top module: `intx_ctl`

## Requirements
- R1: After reset, every register bit reads as 0 and `irq_out` is 0.
- R2: On any clock edge where `intx_in[i]` is 1, status bit 28+i is 1 afterwards, whether or not line i is enabled. Line i is INTA for i=0 through INTD for i=3.
- R3: A write with byte enable 3 set clears status bit 28+i where `wr_data[28+i]` is 1. A status bit written with 0 keeps its value.
- R4: `irq_out` equals, one clock later, the OR over i of (status bit 28+i AND enable bit 22+i). An enable bit of 1 unmasks its line.
- R5: Bits 27..16 (the error-event and line enables), bits 14..8 (master priority for requesters 6..0) and bits 3..0 (TRDY wait) store the written value and read it back.
- R6: Bit 15 and bits 7..4 always read as 0, whatever is written to them.
- R7: Byte enable k (`wr_be[k]`) gates bits 8k+7..8k. A byte whose enable is 0 keeps its stored value, and for byte 3 this includes its status bits.
- R8: When a line is asserted on the same edge as a write of 1 to its status bit, the bit ends up set.
- R9: A write with `wr_be`=4'b1100 and `wr_data[31:16]`=0xF000 clears all four status bits (for lines that are idle on that edge) and all of bits 27..16. Bits 15..0 are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_in | input | 4 | Interrupt lines INTA..INTD, active high |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| irq_out | output | 1 | Combined, registered interrupt request |

## Verification
Two events can fall on the same clock edge: an interrupt line setting its status bit, and a software acknowledge clearing that bit. The bench provokes this by holding every line pattern high while it writes ones to the whole status field. It then does the same for partial overlaps between lines and acknowledge bits. It judges the result by reading back the status field, which must equal the old status with the acknowledged bits removed, ORed with the lines asserted on that edge. The zero-status read-modify-write and the 0xF000 halfword write are run while other lines are pending, so the bench can show which bits survive.

// File: rtl/intx_ctl.sv
module intx_ctl #(
  parameter int LINES   = 4,
  parameter int DW      = 32,
  parameter int STS_LSB = 28,
  parameter int EN_LSB  = 22,
  parameter logic [31:0] RW_MASK = 32'h0FFF_7F0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      intx_in,
  input  logic            wr_en,
  input  logic [3:0]      wr_be,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            irq_out
);
  localparam int BYTES   = DW / 8;
  localparam int STS_BYTE = STS_LSB / 8;

  logic [LINES-1:0] sts_q;
  logic [LINES-1:0] line_en;
  logic [LINES-1:0] ack;
  logic [DW-1:0]    cfg_q;
  logic             irq_q;

  assign ack     = (wr_en && wr_be[STS_BYTE]) ? wr_data[STS_LSB +: LINES] : '0;
  assign line_en = cfg_q[EN_LSB +: LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~ack) | intx_in;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[8*b +: 8] <= '0;
      else if (wr_en && wr_be[b])
        cfg_q[8*b +: 8] <= wr_data[8*b +: 8] & RW_MASK[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(sts_q & line_en);
  end

  assign irq_out = irq_q;

  always_comb begin
    rd_data = cfg_q;
    rd_data[STS_LSB +: LINES] = sts_q;
  end

  assert_line_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|intx_in) |=> ((rd_data[STS_LSB +: LINES] & $past(intx_in)) == $past(intx_in)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[3] && intx_in == '0)
      |=> (rd_data[STS_LSB +: LINES] == ($past(rd_data[STS_LSB +: LINES]) & ~$past(wr_data[STS_LSB +: LINES]))));

  assert_irq_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(rd_data[STS_LSB +: LINES] & rd_data[EN_LSB +: LINES])));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] == 1'b0) && (rd_data[7:4] == 4'd0));

  assert_lane_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[0]) |=> $stable(rd_data[7:0]));
endmodule

// File: tb/test_intx_ctl.sv
module test_intx_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WMASK = 32'h0FFF_7F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic [3:0]  m_sts = '0;
  logic [31:0] m_cfg = '0;
  logic        m_irq = 1'b0;

  intx_ctl i_intx_ctl (
    .clk(clk), .rst_n(rst_n), .intx_in(intx_in), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] lines, logic we, logic [3:0] be, logic [31:0] d);
    logic [3:0] ack;
    @(negedge clk);
    intx_in = lines; wr_en = we; wr_be = be; wr_data = d;
    @(posedge clk);
    #1;
    m_irq = |(m_sts & m_cfg[25:22]);
    ack = (we && be[3]) ? d[31:28] : 4'd0;
    m_sts = (m_sts & ~ack) | lines;
    for (int b = 0; b < 4; b++)
      if (we && be[b]) m_cfg[8*b +: 8] = d[8*b +: 8] & WMASK[8*b +: 8];
    chk(tag, rd_data, {m_sts, m_cfg[27:0]});
    chk({tag, "_irq"}, {31'd0, irq_out}, {31'd0, m_irq});
    intx_in = '0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1_reset_rd", rd_data, 32'd0);
    chk("R1_reset_irq", {31'd0, irq_out}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step("R1_idle", 4'd0, 1'b0, 4'd0, 32'd0);
    step("R5_R6_all_ones", 4'd0, 1'b1, 4'hF, 32'hFFFF_FFFF);
    step("R5_pattern", 4'd0, 1'b1, 4'hF, 32'h0A5A_2A09);
    step("R6_reserved", 4'd0, 1'b1, 4'hF, 32'h0000_80F0);

    for (int be = 0; be < 16; be++) begin
      step("R7_lane_prep", 4'd0, 1'b1, 4'hF, 32'h0555_5505);
      step("R7_lane", 4'd0, 1'b1, be[3:0], 32'hFAAA_AAAA);
    end

    step("R2_clear", 4'd0, 1'b1, 4'hF, 32'hF000_0000);
    for (int l = 0; l < 16; l++) begin
      step("R2_latch_masked", l[3:0], 1'b0, 4'd0, 32'd0);
      step("R2_hold", 4'd0, 1'b0, 4'd0, 32'd0);
      step("R3_ack", 4'd0, 1'b1, 4'h8, 32'hF000_0000);
    end

    for (int en = 0; en < 16; en++)
      for (int s = 0; s < 16; s++) begin
        step("R4_en", 4'd0, 1'b1, 4'hC, {4'hF, 2'b00, en[3:0], 6'd0, 16'd0});
        step("R4_set", s[3:0], 1'b0, 4'd0, 32'd0);
        step("R4_out", 4'd0, 1'b0, 4'd0, 32'd0);
        step("R4_out2", 4'd0, 1'b0, 4'd0, 32'd0);
      end

    for (int l = 0; l < 16; l++)
      for (int a = 0; a < 16; a++) begin
        step("R8_pend", 4'hF, 1'b0, 4'd0, 32'd0);
        step("R8_collide", l[3:0], 1'b1, 4'h8, {a[3:0], 28'd0});
        step("R3_partial", 4'd0, 1'b1, 4'h8, {a[3:0], 28'd0});
      end

    step("R5_rmw_pend", 4'hB, 1'b0, 4'd0, 32'd0);
    step("R5_rmw_zero", 4'd0, 1'b1, 4'hF, 32'h03C0_1203);
    step("R3_zero_write", 4'd0, 1'b1, 4'h8, 32'h0000_0000);

    step("R9_prep", 4'hF, 1'b1, 4'hF, 32'h0FFF_7F0F);
    step("R9_halfword", 4'd0, 1'b1, 4'hC, 32'hF000_0000);
    chk("R9_upper_zero", {16'd0, rd_data[31:16]}, 32'd0);
    chk("R9_lower_kept", {16'd0, rd_data[15:0]}, 32'h0000_7F0F);
    step("R9_prep2", 4'h6, 1'b1, 4'hC, 32'h0FFF_0000);
    step("R9_halfword_line", 4'h2, 1'b1, 4'hC, 32'hF000_0000);
    step("R9_after", 4'd0, 1'b0, 4'd0, 32'd0);

    finish_run();
  end
endmodule